// File: doc/BRIEF.md
# Boot Flash Block Copy Engine

This block copies whole 64-byte granules from a boot flash read port into system memory. Software loads a source address, a destination address and a control word. The control word holds a granule count, a failure flag and a start bit. The start bit acts as the busy indicator until the copy finishes. The engine fetches one 32-bit word at a time from the flash and writes it to memory at the next destination address.

The flash port is shared with direct memory-mapped reads from elsewhere in the chip. A small arbiter keeps one flash request in flight at a time and routes each response back to whoever issued it. Mapped reads win the port. With the safe mode input set, the copy waits for a real response before every memory write. With it clear, the engine keeps the older behaviour: a word whose flash slot was taken by a mapped read is written as zero.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset the source, destination and control registers all read as zero, and no flash request, memory write or done pulse is issued.
- R2: The source register sits at offset 0xB0 and the destination register at 0xB4. Both read back the written value with bits 5:0 forced to zero.
- R3: In the control register at 0xB8, writing 1 to bit 0 while idle starts a copy. Bit 0 reads 1 from the next cycle until the last word is written, then reads 0. `done` is high for exactly one cycle, together with the last memory write.
- R4: A copy moves (L+1)*16 words, where L is control bits 15:6. Word i is read from flash at source+4i and written to memory at destination+4i with that flash data.
- R5: Control bits 24 and 23 hold whatever was last written to them and are not touched by copies. Control bits other than 0, 1, 15:6, 23 and 24 read as zero.
- R6: A flash response for the copy that carries an error sets control bit 1 and returns the engine to idle, with no further memory writes. Writing 1 to bit 1 clears it, including within the write that sets start.
- R7: With safe mode set, a mapped read takes the flash port first and the copy stalls, so every memory write carries flash data for its own address.
- R8: With safe mode clear, a copy word whose flash slot is taken by a mapped read is written as zero, and the copy moves on to the next word.
- R9: While busy, writes to the source register, the destination register or the length field are ignored, and a start write has no effect.
- R10: At most one flash request is outstanding at a time. A mapped read receives its own response with the flash data for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fix_en | input | 1 | Safe mode: copy stalls behind mapped reads |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| map_req | input | 1 | Mapped read request, held until answered |
| map_addr | input | 32 | Mapped read address |
| map_rvalid | output | 1 | Mapped read response valid |
| map_rdata | output | 32 | Mapped read response data |
| fl_req | output | 1 | Flash read issue, one cycle |
| fl_addr | output | 32 | Flash read address |
| fl_rvalid | input | 1 | Flash response valid |
| fl_rdata | input | 32 | Flash response data |
| fl_rerr | input | 1 | Flash response error |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | One-cycle pulse on the last word of a copy |

## Verification
The hardest state to reach is a copy that is ready to read at the very cycle the flash port frees up while a mapped read is also pending. That collision is the only case in which safe mode and the older mode behave differently. The stimulus reaches it by starting a stream of back-to-back mapped reads in the same cycle as the start write and holding the request high between responses. Every time the port frees, both requesters then compete. In safe mode the copy starves until the stream ends and must still deliver correct data. In the older mode the bench expects zero words mixed with correct ones at the right addresses.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_WRITE = 2'd3
  } seq_state_t;

  typedef enum logic {
    OWN_DMA = 1'b0,
    OWN_MAP = 1'b1
  } port_owner_t;

  // Number of bus words moved for a length field value.
  function automatic int unsigned words_for_len(input int unsigned len_field,
                                                input int unsigned gran_bytes,
                                                input int unsigned word_bytes);
    return (len_field + 1) * (gran_bytes / word_bytes);
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int DW      = 32,
  parameter int LEN_W   = 10,
  parameter int LEN_LSB = 6,
  parameter int GRAN_LG = 6,
  parameter int PF_LO   = 23,
  parameter int PF_HI   = 24,
  parameter logic [7:0] SRC_OFF = 8'hB0,
  parameter logic [7:0] DST_OFF = 8'hB4,
  parameter logic [7:0] CTL_OFF = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             busy,
  input  logic             err_set,
  output logic             go,
  output logic [LEN_W-1:0] go_len,
  output logic [DW-1:0]    src_o,
  output logic [DW-1:0]    dst_o
);
  localparam logic [DW-1:0] ALIGN_MASK = {DW{1'b1}} << GRAN_LG;

  logic [DW-1:0]    src_q, dst_q;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       pf_q;
  logic             err_q;
  logic             wr_src, wr_dst, wr_ctl;
  logic             unused_wdata;

  assign wr_src = reg_we && (reg_addr == SRC_OFF);
  assign wr_dst = reg_we && (reg_addr == DST_OFF);
  assign wr_ctl = reg_we && (reg_addr == CTL_OFF);
  assign go     = wr_ctl && reg_wdata[0] && !busy;
  assign go_len = reg_wdata[LEN_LSB +: LEN_W];
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      pf_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_src && !busy) src_q <= reg_wdata & ALIGN_MASK;
      if (wr_dst && !busy) dst_q <= reg_wdata & ALIGN_MASK;
      if (wr_ctl) begin
        pf_q <= {reg_wdata[PF_HI], reg_wdata[PF_LO]};
        if (!busy) len_q <= reg_wdata[LEN_LSB +: LEN_W];
      end
      if (err_set)                      err_q <= 1'b1;
      else if (wr_ctl && reg_wdata[1])  err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      SRC_OFF: reg_rdata = src_q;
      DST_OFF: reg_rdata = dst_q;
      CTL_OFF: begin
        reg_rdata[0]                 = busy;
        reg_rdata[1]                 = err_q;
        reg_rdata[LEN_LSB +: LEN_W]  = len_q;
        reg_rdata[PF_LO]             = pf_q[0];
        reg_rdata[PF_HI]             = pf_q[1];
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_port_arb.sv
module flash_port_arb
  import flash_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_en,
  input  logic          map_req,
  input  logic [DW-1:0] map_addr,
  input  logic          dma_want,
  input  logic [DW-1:0] dma_addr,
  input  logic          fl_rvalid,
  input  logic          fl_rerr,
  output logic          fl_req,
  output logic [DW-1:0] fl_addr,
  output logic          map_rvalid,
  output logic          dma_grant,
  output logic          dma_lost,
  output logic          dma_rvalid,
  output logic          dma_rsp_ok,
  output logic          dma_rsp_err
);
  logic        busy_q;
  port_owner_t own_q;
  logic        map_go;

  assign map_go    = !busy_q && map_req;
  assign dma_grant = !busy_q && !map_req && dma_want;
  assign dma_lost  = map_go && dma_want && !fix_en;
  assign fl_req    = map_go || dma_grant;
  assign fl_addr   = map_go ? map_addr : dma_addr;

  assign map_rvalid  = fl_rvalid && busy_q && (own_q == OWN_MAP);
  assign dma_rvalid  = fl_rvalid && busy_q && (own_q == OWN_DMA);
  assign dma_rsp_ok  = dma_rvalid && !fl_rerr;
  assign dma_rsp_err = dma_rvalid && fl_rerr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= OWN_DMA;
    end else if (fl_req) begin
      busy_q <= 1'b1;
      own_q  <= map_go ? OWN_MAP : OWN_DMA;
    end else if (fl_rvalid) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import flash_dma_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LEN_W   = 10,
  parameter int GRAN_LG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] go_len,
  input  logic [DW-1:0]    src,
  input  logic [DW-1:0]    dst,
  input  logic             dma_grant,
  input  logic             dma_lost,
  input  logic             dma_rvalid,
  input  logic [DW-1:0]    dma_rdata,
  input  logic             dma_rerr,
  output logic             dma_want,
  output logic [DW-1:0]    rd_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             done,
  output logic             busy,
  output logic             err_set
);
  localparam int WORD_BYTES = DW / 8;
  localparam int GRAN_BYTES = 1 << GRAN_LG;
  localparam int CNT_W      = LEN_W + $clog2(GRAN_BYTES / WORD_BYTES) + 1;

  seq_state_t       st;
  logic [DW-1:0]    rp, wp, data_q;
  logic [CNT_W-1:0] left;
  logic             last_word;

  assign dma_want  = (st == SQ_READ);
  assign rd_addr   = rp;
  assign mem_we    = (st == SQ_WRITE);
  assign mem_addr  = wp;
  assign mem_wdata = data_q;
  assign last_word = (left == CNT_W'(1));
  assign done      = mem_we && last_word;
  assign busy      = (st != SQ_IDLE);
  assign err_set   = (st == SQ_WAIT) && dma_rvalid && dma_rerr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      rp     <= '0;
      wp     <= '0;
      left   <= '0;
      data_q <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (go) begin
          rp   <= src;
          wp   <= dst;
          left <= CNT_W'(words_for_len(int'(go_len), GRAN_BYTES, WORD_BYTES));
          st   <= SQ_READ;
        end
        SQ_READ: begin
          if (dma_grant) st <= SQ_WAIT;
          else if (dma_lost) begin
            data_q <= '0;
            st     <= SQ_WRITE;
          end
        end
        SQ_WAIT: if (dma_rvalid) begin
          if (dma_rerr) st <= SQ_IDLE;
          else begin
            data_q <= dma_rdata;
            st     <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          rp   <= rp + DW'(WORD_BYTES);
          wp   <= wp + DW'(WORD_BYTES);
          left <= left - CNT_W'(1);
          st   <= last_word ? SQ_IDLE : SQ_READ;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_dma_engine.sv
module flash_dma_engine #(
  parameter int DW      = 32,
  parameter int LEN_W   = 10,
  parameter int LEN_LSB = 6,
  parameter int GRAN_LG = 6,
  parameter int PF_LO   = 23,
  parameter int PF_HI   = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_en,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          map_req,
  input  logic [DW-1:0] map_addr,
  output logic          map_rvalid,
  output logic [DW-1:0] map_rdata,
  output logic          fl_req,
  output logic [DW-1:0] fl_addr,
  input  logic          fl_rvalid,
  input  logic [DW-1:0] fl_rdata,
  input  logic          fl_rerr,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done
);
  logic             busy_w, err_set, go;
  logic [LEN_W-1:0] go_len;
  logic [DW-1:0]    src_q, dst_q, rd_addr;
  logic             dma_want, dma_grant, dma_lost, dma_rvalid;
  logic             dma_rsp_ok, dma_rsp_err;

  assign map_rdata = fl_rdata;

  dma_regs #(
    .DW(DW), .LEN_W(LEN_W), .LEN_LSB(LEN_LSB), .GRAN_LG(GRAN_LG),
    .PF_LO(PF_LO), .PF_HI(PF_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
    .err_set(err_set), .go(go), .go_len(go_len), .src_o(src_q), .dst_o(dst_q)
  );

  flash_port_arb #(.DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n), .fix_en(fix_en),
    .map_req(map_req), .map_addr(map_addr),
    .dma_want(dma_want), .dma_addr(rd_addr),
    .fl_rvalid(fl_rvalid), .fl_rerr(fl_rerr),
    .fl_req(fl_req), .fl_addr(fl_addr), .map_rvalid(map_rvalid),
    .dma_grant(dma_grant), .dma_lost(dma_lost), .dma_rvalid(dma_rvalid),
    .dma_rsp_ok(dma_rsp_ok), .dma_rsp_err(dma_rsp_err)
  );

  dma_seq #(.DW(DW), .LEN_W(LEN_W), .GRAN_LG(GRAN_LG)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_len(go_len),
    .src(src_q), .dst(dst_q),
    .dma_grant(dma_grant), .dma_lost(dma_lost), .dma_rvalid(dma_rvalid),
    .dma_rdata(fl_rdata), .dma_rerr(fl_rerr),
    .dma_want(dma_want), .rd_addr(rd_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .busy(busy_w), .err_set(err_set)
  );
endmodule

// File: rtl/flash_dma_chk.sv
module flash_dma_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fix_en,
  input logic          fl_req,
  input logic          mem_we,
  input logic          done,
  input logic          busy,
  input logic          dma_rsp_ok,
  input logic          dma_rsp_err,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] src_reg
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req); // R10
  AST_SAFE_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && mem_we) |-> $past(dma_rsp_ok)); // R7
  AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rsp_err |=> (!mem_we && !busy)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_we); // R3
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00)); // R4
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(src_reg)); // R9
endmodule

bind flash_dma_engine flash_dma_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fix_en(fix_en), .fl_req(fl_req),
  .mem_we(mem_we), .done(done), .busy(busy_w), .dma_rsp_ok(dma_rsp_ok),
  .dma_rsp_err(dma_rsp_err), .mem_addr(mem_addr), .src_reg(src_q)
);

// File: tb/sim_flash_dma_engine.sv
`timescale 1ns/1ps
module sim_flash_dma_engine;
  localparam logic [7:0] A_SRC = 8'hB0, A_DST = 8'hB4, A_CTL = 8'hB8;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, fix_en = 1'b1;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic map_req = 1'b0;
  logic [31:0] map_addr = '0, map_rdata;
  logic map_rvalid, fl_req, mem_we, done;
  logic [31:0] fl_addr, mem_addr, mem_wdata;
  logic fl_rvalid = 1'b0, fl_rerr = 1'b0;
  logic [31:0] fl_rdata = '0;

  int vecs = 0, bad = 0;
  logic err_inj = 1'b0;
  logic [31:0] err_addr = '0;

  always #2 clk = ~clk;

  flash_dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .fix_en(fix_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .map_req(map_req), .map_addr(map_addr), .map_rvalid(map_rvalid),
    .map_rdata(map_rdata), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata), .fl_rerr(fl_rerr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) | 32'h1;
  endfunction

  // flash model: fixed latency, one request at a time
  logic        pend = 1'b0;
  logic [31:0] pa = '0;
  int          cnt = 0;
  always @(posedge clk) begin
    fl_rvalid <= 1'b0;
    if (fl_req) begin
      pend <= 1'b1; pa <= fl_addr; cnt <= LAT;
    end else if (pend) begin
      if (cnt == 1) begin
        fl_rvalid <= 1'b1; fl_rdata <= fdat(pa);
        fl_rerr <= err_inj && (pa == err_addr); pend <= 1'b0;
      end
      cnt <= cnt - 1;
    end
  end

  // memory write log
  logic [31:0] log_a [0:255];
  logic [31:0] log_d [0:255];
  int nwr = 0, ndone = 0;
  always @(posedge clk) begin
    if (mem_we && nwr < 256) begin
      log_a[nwr] <= mem_addr; log_d[nwr] <= mem_wdata;
    end
    if (mem_we) nwr <= nwr + 1;
    if (done) ndone <= ndone + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(A_CTL, c);
      if (!c[0]) break;
    end
  endtask

  task automatic map_stream(input logic [31:0] a0, input int n);
    logic [31:0] a = a0;
    @(negedge clk); map_req = 1'b1; map_addr = a;
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!map_rvalid);
      check("R10 map data", map_rdata, fdat(a));
      a = a + 4; map_addr = a;
      if (k == n - 1) map_req = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(A_SRC, v); check("R1 src", v, 0);
    rd(A_DST, v); check("R1 dst", v, 0);
    rd(A_CTL, v); check("R1 ctl", v, 0);
    check("R1 idle outputs", {29'b0, fl_req, mem_we, done}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_SRC, 32'h1234_5677); rd(A_SRC, v); check("R2 src align", v, 32'h1234_5640);
    wr(A_DST, 32'hFFFF_FFFF); rd(A_DST, v); check("R2 dst align", v, 32'hFFFF_FFC0);
    wr(A_CTL, 32'hFFFF_FFFE); rd(A_CTL, v); check("R5 ctl layout", v, 32'h0180_FFC0);
    wr(A_CTL, 32'h0080_0000); rd(A_CTL, v); check("R5 pf bits independent", v, 32'h0080_0000);
  endtask

  task automatic t_copy(input logic [31:0] s, input logic [31:0] d, input int len);
    logic [31:0] v;
    int base = nwr, db = ndone, words = (len + 1) * 16;
    wr(A_SRC, s); wr(A_DST, d);
    wr(A_CTL, 32'h0100_0001 | (32'(len) << 6));
    rd(A_CTL, v); check("R3 busy after start", {31'b0, v[0]}, 1);
    wait_idle();
    check("R4 word count", nwr - base, words);
    check("R3 one done", ndone - db, 1);
    for (int i = 0; i < words; i++) begin
      check("R4 addr", log_a[base+i], d + 4*i);
      check("R4 data", log_d[base+i], fdat(s + 4*i));
    end
    rd(A_CTL, v); check("R5 pf kept after copy", v, 32'h0100_0000 | (32'(len) << 6));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int base = nwr;
    wr(A_SRC, 32'h4000); wr(A_DST, 32'h9000);
    wr(A_CTL, 32'h0000_0001);
    wr(A_SRC, 32'h7700); wr(A_DST, 32'h7800);
    wr(A_CTL, 32'h0000_01C1);
    wait_idle();
    repeat (20) @(negedge clk);
    check("R9 no restart", nwr - base, 16);
    rd(A_SRC, v); check("R9 src kept", v, 32'h4000);
    rd(A_DST, v); check("R9 dst kept", v, 32'h9000);
    rd(A_CTL, v); check("R9 len kept", v, 0);
    check("R9 first dest", log_a[base], 32'h9000);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int base = nwr;
    err_inj = 1'b1; err_addr = 32'h2000 + 20;
    wr(A_SRC, 32'h2000); wr(A_DST, 32'hA000);
    wr(A_CTL, 32'h0000_0041);
    wait_idle();
    repeat (5) @(negedge clk);
    check("R6 writes before error", nwr - base, 5);
    rd(A_CTL, v); check("R6 error set, idle", v[1:0], 2'b10);
    wr(A_CTL, 32'h0000_0002); rd(A_CTL, v); check("R6 w1c", v[1:0], 2'b00);
    wr(A_CTL, 32'h0000_0041); wait_idle();
    rd(A_CTL, v); check("R6 set again", v[1:0], 2'b10);
    err_inj = 1'b0; base = nwr;
    wr(A_CTL, 32'h0000_0003); wait_idle();
    rd(A_CTL, v); check("R6 start clears error", v[1:0], 2'b00);
    check("R6 clean copy", nwr - base, 16);
  endtask

  task automatic t_mapped(input logic safe);
    int base = nwr, zeros = 0, goodw = 0;
    fix_en = safe;
    wr(A_SRC, 32'h3000); wr(A_DST, 32'hB000);
    fork
      wr(A_CTL, 32'h0000_0001);
      map_stream(32'h5000, 8);
    join
    wait_idle();
    check(safe ? "R7 count" : "R8 count", nwr - base, 16);
    for (int i = 0; i < 16; i++) begin
      check(safe ? "R7 addr" : "R8 addr", log_a[base+i], 32'hB000 + 4*i);
      if (log_d[base+i] == 0) zeros++;
      else if (log_d[base+i] == fdat(32'h3000 + 4*i)) goodw++;
    end
    if (safe) check("R7 all words correct", goodw, 16);
    else begin
      check("R8 some zeros", {31'b0, zeros > 0}, 1);
      check("R8 zero or correct", zeros + goodw, 16);
    end
    fix_en = 1'b1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_copy(32'h1000, 32'h8000, 1);
    t_copy(32'h6040, 32'hC0C0, 0);
    t_busy_ignore();
    t_error();
    t_mapped(1'b1);
    t_mapped(1'b0);
    report();
  end
endmodule